// File: doc/BRIEF.md
# Memory Fault Capture and Interrupt Unit

This unit sits beside a memory controller and records faulting accesses of three kinds: an access that decodes to no external memory, an access that hits an invalid page in the address translation table, and an access that breaks a security rule. Each kind reports on its own strobe, one cycle at a time, with the requesting client number, the access direction and the faulting address. The security strobe also carries a flag that tells which kind of violation was found.

For each kind the unit stores a formatted status word and the faulting address in a pair of registers. The address sits in the word just above its status word. The unit also sets one bit per kind in an interrupt status register. Software clears these bits by writing ones to them, and a mask register picks which kinds drive the single interrupt line. While a kind's bit is set, the first fault stays captured. A fault that arrives in the same cycle that software clears its bit replaces the old capture and leaves the bit set.

Top module: `mem_fault_capture`

## Requirements
- R1: After a synchronous active-low reset, every status bit, the mask, every captured status word and every captured address read as zero, and `irq` is low.
- R2: The decode-fault status word (offset 0x10) holds the 6-bit client number in bits [5:0] and the direction in bit 31 (1 = write). Its faulting address reads at offset 0x14.
- R3: The translation-fault status word (offset 0x18) holds the direction in bit 0 (1 = write) and the client number in bits [6:1]. Its faulting address reads at offset 0x1C.
- R4: The security-fault status word (offset 0x20) holds the client number in bits [5:0], the violation-type flag in bit 30 and the direction in bit 31 (1 = write). Its faulting address reads at offset 0x24.
- R5: A fault strobe sets its bit in the interrupt status register (offset 0x00; bit 0 decode, bit 1 translation, bit 2 security) at the next clock edge and captures its fields at the same edge.
- R6: While a kind's status bit is set and is not being cleared, later faults of that kind do not change its captured status word or address.
- R7: A register write to offset 0x00 clears each status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R8: The mask register (offset 0x04, bits [2:0], same bit order as the status register) is read/write, and `irq` is high exactly when some status bit and its mask bit are both 1.
- R9: When a fault strobe and a write-one clear of the same bit arrive in the same cycle, the bit stays set and the new fault is captured.
- R10: Writes to the capture registers are ignored. Reads of any offset other than 0x00, 0x04 and 0x10 to 0x24 (word aligned) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_err_vld | input | 1 | Decode-fault strobe |
| dec_err_client | input | ID_W (6) | Client number of the decode fault |
| dec_err_write | input | 1 | Decode fault was a write |
| dec_err_addr | input | DATA_W (32) | Faulting address of the decode fault |
| xl_err_vld | input | 1 | Translation-fault strobe |
| xl_err_client | input | ID_W (6) | Client number of the translation fault |
| xl_err_write | input | 1 | Translation fault was a write |
| xl_err_addr | input | DATA_W (32) | Faulting address of the translation fault |
| sv_err_vld | input | 1 | Security-fault strobe |
| sv_err_client | input | ID_W (6) | Client number of the security fault |
| sv_err_write | input | 1 | Security fault was a write |
| sv_err_kind | input | 1 | Violation-type flag of the security fault |
| sv_err_addr | input | DATA_W (32) | Faulting address of the security fault |
| reg_addr | input | REG_AW (6) | Byte offset for register read and write |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | NUM_SRC (3) | Write data; all writable registers are NUM_SRC bits wide |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`, combinational |
| irq | output | 1 | Masked interrupt line |

## Verification
The assertions check on every cycle that a strobe sets its status bit, that a captured word stays unchanged while its bit is held, that a write-one clear without a fault drops the bit, that a capture takes the strobe's address, and that `irq` stays low when no set bit is unmasked. Only the bench scenarios show the bit layouts of the three status words, the register offsets, and that unmapped or read-only writes leave the readable state untouched. The same holds for the collision of a clear with a fault. The random phase mixes overlapping strobes, clears and mask changes against a bench model. Every cycle it reads back a mapped or unmapped offset.

// File: rtl/mem_fault_pkg.sv
// Package: shared constants, source ordering and status-word formatting
// for the memory fault capture unit.
// Assumes: client numbers are at most 29 bits so they stay clear of
// bits 30 and 31 of the status word.
package mem_fault_pkg;

    // Source ordering; the value is the bit position in the interrupt status register.
    typedef enum logic [1:0] {
        SRC_DECODE   = 2'd0,
        SRC_XLATE    = 2'd1,
        SRC_SECURITY = 2'd2
    } fault_src_e;

    localparam int NUM_SRC    = 3;
    localparam int OFS_STATUS = 0;
    localparam int OFS_MASK   = 4;
    localparam int OFS_CAP0   = 16;
    localparam int CAP_STRIDE = 8;

    // Byte offset of the captured status word of source i.
    function automatic int cap_status_ofs(input int i);
        return OFS_CAP0 + CAP_STRIDE * i;
    endfunction

    // Byte offset of the captured address of source i: one word above its status.
    function automatic int cap_addr_ofs(input int i);
        return OFS_CAP0 + CAP_STRIDE * i + 4;
    endfunction

    // Build the 32-bit status word for a source from its raw fault fields.
    function automatic logic [31:0] fmt_status(input fault_src_e src,
                                               input logic [31:0] client,
                                               input logic        is_write,
                                               input logic        kind_flag);
        logic [31:0] w;
        case (src)
            SRC_DECODE:   w = client | ({31'd0, is_write} << 31);
            SRC_XLATE:    w = (client << 1) | {31'd0, is_write};
            SRC_SECURITY: w = client | ({31'd0, kind_flag} << 30)
                                     | ({31'd0, is_write} << 31);
            default:      w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/fault_capture_slot.sv
// Module: one capture slot. It holds the sticky pending bit, the status word
// and the faulting address of one fault source.
// Assumes: the status word comes in already formatted; clr is a one-cycle
// write-one-to-clear request for this slot's bit.
module fault_capture_slot #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [DATA_W-1:0] word_in,
    input  logic [DATA_W-1:0] addr_in,
    input  logic              clr,
    output logic              pend_o,
    output logic [DATA_W-1:0] status_o,
    output logic [DATA_W-1:0] addr_o
);

    logic take;

    // A fault is taken when the slot is empty or is being cleared this cycle.
    always_comb take = strobe && (!pend_o || clr);

    // Pending bit: set by a strobe, dropped by a clear, and a strobe wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= 1'b0;
        else        pend_o <= strobe || (pend_o && !clr);
    end

    // Capture registers: load on a taken fault and hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o <= '0;
            addr_o   <= '0;
        end else if (take) begin
            status_o <= word_in;
            addr_o   <= addr_in;
        end
    end

endmodule

// File: rtl/fault_irq_ctrl.sv
// Module: interrupt mask register and masked interrupt line.
// Assumes: mask_we comes from the register decoder and pend is the vector
// of slot pending bits.
module fault_irq_ctrl #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mask_we,
    input  logic [NSRC-1:0] mask_wdata,
    input  logic [NSRC-1:0] pend,
    output logic [NSRC-1:0] mask_q,
    output logic            irq
);

    // Mask register: loaded by a register write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    // Interrupt line: any pending source whose mask bit is set.
    always_comb irq = |(pend & mask_q);

endmodule

// File: rtl/fault_reg_map.sv
// Module: register decoder and read multiplexer.
// Assumes: word-aligned byte offsets; only the status clear and the mask
// are writable, and every other write is dropped here.
module fault_reg_map
    import mem_fault_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_AW = 6,
    parameter int NSRC   = NUM_SRC
) (
    input  logic [REG_AW-1:0]            reg_addr,
    input  logic                         reg_wr,
    input  logic [NSRC-1:0]              reg_wdata,
    input  logic [NSRC-1:0]              pend,
    input  logic [NSRC-1:0]              mask_q,
    input  logic [NSRC-1:0][DATA_W-1:0]  cap_sts,
    input  logic [NSRC-1:0][DATA_W-1:0]  cap_addr,
    output logic [NSRC-1:0]              clr,
    output logic                         mask_we,
    output logic [DATA_W-1:0]            rdata
);

    localparam logic [REG_AW-1:0] A_STATUS = REG_AW'(OFS_STATUS);
    localparam logic [REG_AW-1:0] A_MASK   = REG_AW'(OFS_MASK);

    // Write decode: write-one-to-clear on the status offset, load on the mask offset.
    always_comb begin
        clr     = (reg_wr && reg_addr == A_STATUS) ? reg_wdata : '0;
        mask_we = reg_wr && reg_addr == A_MASK;
    end

    // Read multiplexer: unmapped offsets read as zero.
    always_comb begin
        rdata = '0;
        if (reg_addr == A_STATUS) rdata = DATA_W'(pend);
        if (reg_addr == A_MASK)   rdata = DATA_W'(mask_q);
        for (int i = 0; i < NSRC; i++) begin
            if (reg_addr == REG_AW'(cap_status_ofs(i))) rdata = cap_sts[i];
            if (reg_addr == REG_AW'(cap_addr_ofs(i)))   rdata = cap_addr[i];
        end
    end

endmodule

// File: rtl/mem_fault_capture.sv
// Module: top of the memory fault capture and interrupt unit. It formats the
// three fault strobes, captures the first fault of each kind, and exposes
// status, mask and capture registers with a masked interrupt line.
// Assumes: strobes last one cycle per fault; ID_W <= 29; register reads
// are combinational.
module mem_fault_capture
    import mem_fault_pkg::*;
#(
    parameter int ID_W   = 6,
    parameter int DATA_W = 32,
    parameter int REG_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_err_vld,
    input  logic [ID_W-1:0]   dec_err_client,
    input  logic              dec_err_write,
    input  logic [DATA_W-1:0] dec_err_addr,
    input  logic              xl_err_vld,
    input  logic [ID_W-1:0]   xl_err_client,
    input  logic              xl_err_write,
    input  logic [DATA_W-1:0] xl_err_addr,
    input  logic              sv_err_vld,
    input  logic [ID_W-1:0]   sv_err_client,
    input  logic              sv_err_write,
    input  logic              sv_err_kind,
    input  logic [DATA_W-1:0] sv_err_addr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    logic [NUM_SRC-1:0]             strobe;
    logic [NUM_SRC-1:0][DATA_W-1:0] word_in;
    logic [NUM_SRC-1:0][DATA_W-1:0] addr_in;
    logic [NUM_SRC-1:0]             clr;
    logic [NUM_SRC-1:0]             pend;
    logic [NUM_SRC-1:0]             mask_q;
    logic [NUM_SRC-1:0][DATA_W-1:0] cap_sts;
    logic [NUM_SRC-1:0][DATA_W-1:0] cap_addr;
    logic                           mask_we;

    // Gather the strobes and format each source's status word.
    always_comb begin
        strobe  = {sv_err_vld, xl_err_vld, dec_err_vld};
        addr_in = {sv_err_addr, xl_err_addr, dec_err_addr};
        word_in[SRC_DECODE]   = fmt_status(SRC_DECODE, 32'(dec_err_client),
                                           dec_err_write, 1'b0);
        word_in[SRC_XLATE]    = fmt_status(SRC_XLATE, 32'(xl_err_client),
                                           xl_err_write, 1'b0);
        word_in[SRC_SECURITY] = fmt_status(SRC_SECURITY, 32'(sv_err_client),
                                           sv_err_write, sv_err_kind);
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
        fault_capture_slot #(.DATA_W(DATA_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe   (strobe[i]),
            .word_in  (word_in[i]),
            .addr_in  (addr_in[i]),
            .clr      (clr[i]),
            .pend_o   (pend[i]),
            .status_o (cap_sts[i]),
            .addr_o   (cap_addr[i])
        );
    end

    fault_irq_ctrl #(.NSRC(NUM_SRC)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_we    (mask_we),
        .mask_wdata (reg_wdata),
        .pend       (pend),
        .mask_q     (mask_q),
        .irq        (irq)
    );

    fault_reg_map #(.DATA_W(DATA_W), .REG_AW(REG_AW), .NSRC(NUM_SRC)) u_map (
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .pend      (pend),
        .mask_q    (mask_q),
        .cap_sts   (cap_sts),
        .cap_addr  (cap_addr),
        .clr       (clr),
        .mask_we   (mask_we),
        .rdata     (reg_rdata)
    );

endmodule

// File: rtl/mem_fault_capture_chk.sv
// Module: assertion checker for mem_fault_capture, attached by bind.
// Assumes: it sees the top's strobes, register writes and slot state.
module mem_fault_capture_chk #(
    parameter int NSRC   = 3,
    parameter int DATA_W = 32,
    parameter int REG_AW = 6
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NSRC-1:0]              strobe,
    input logic [NSRC-1:0][DATA_W-1:0]  addr_in,
    input logic [REG_AW-1:0]            reg_addr,
    input logic                         reg_wr,
    input logic [NSRC-1:0]              reg_wdata,
    input logic [NSRC-1:0]              pend,
    input logic [NSRC-1:0]              mask_q,
    input logic [NSRC-1:0][DATA_W-1:0]  cap_sts,
    input logic [NSRC-1:0][DATA_W-1:0]  cap_addr,
    input logic                         irq
);

    logic [NSRC-1:0] wclr;
    always_comb wclr = (reg_wr && reg_addr == '0) ? reg_wdata : '0;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pend == '0 && mask_q == '0 && !irq));

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & mask_q) == '0) |-> !irq);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        // R5
        strobe_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            strobe[i] |=> pend[i]);

        // R6
        first_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[i] && !wclr[i]) |=> ($stable(cap_sts[i]) && $stable(cap_addr[i])));

        // R7
        w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wclr[i] && !strobe[i]) |=> !pend[i]);

        // R9
        take_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (strobe[i] && (!pend[i] || wclr[i])) |=> cap_addr[i] == $past(addr_in[i]));
    end

endmodule

bind mem_fault_capture mem_fault_capture_chk #(
    .NSRC(mem_fault_pkg::NUM_SRC), .DATA_W(DATA_W), .REG_AW(REG_AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .addr_in   (addr_in),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .pend      (pend),
    .mask_q    (mask_q),
    .cap_sts   (cap_sts),
    .cap_addr  (cap_addr),
    .irq       (irq)
);

// File: tb/tb_mem_fault_capture.sv
module tb_mem_fault_capture;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        e_vld  [3];
    logic [5:0]  e_id   [3];
    logic        e_wr   [3];
    logic [31:0] e_addr [3];
    logic        sv_kind;
    logic [5:0]  reg_addr;
    logic        reg_wr;
    logic [2:0]  reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq;

    // Bench model
    logic [2:0]  m_pend;
    logic [2:0]  m_mask;
    logic [31:0] m_sts  [3];
    logic [31:0] m_addr [3];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_fault_capture dut (
        .clk(clk), .rst_n(rst_n),
        .dec_err_vld(e_vld[0]), .dec_err_client(e_id[0]),
        .dec_err_write(e_wr[0]), .dec_err_addr(e_addr[0]),
        .xl_err_vld(e_vld[1]), .xl_err_client(e_id[1]),
        .xl_err_write(e_wr[1]), .xl_err_addr(e_addr[1]),
        .sv_err_vld(e_vld[2]), .sv_err_client(e_id[2]),
        .sv_err_write(e_wr[2]), .sv_err_kind(sv_kind), .sv_err_addr(e_addr[2]),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // Expected status word for source k, from the layouts in R2, R3 and R4.
    function automatic logic [31:0] exp_word(input int k, input logic [5:0] id,
                                             input logic wr, input logic kind);
        logic [31:0] w = 32'd0;
        if (k == 0) begin w[5:0] = id; w[31] = wr; end
        else if (k == 1) begin w[6:1] = id; w[0] = wr; end
        else begin w[5:0] = id; w[30] = kind; w[31] = wr; end
        return w;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [5:0] a);
        case (a)
            6'h00: return {29'd0, m_pend};
            6'h04: return {29'd0, m_mask};
            6'h10: return m_sts[0];
            6'h14: return m_addr[0];
            6'h18: return m_sts[1];
            6'h1C: return m_addr[1];
            6'h20: return m_sts[2];
            6'h24: return m_addr[2];
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [5:0] a);
        case (a)
            6'h00: return "R7";
            6'h04: return "R8";
            6'h10, 6'h14: return "R2";
            6'h18, 6'h1C: return "R3";
            6'h20, 6'h24: return "R4";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle_inputs();
        for (int k = 0; k < 3; k++) begin
            e_vld[k] = 1'b0;
        end
        reg_wr = 1'b0;
        reg_wdata = 3'd0;
    endtask

    task automatic model_reset();
        m_pend = '0;
        m_mask = '0;
        for (int k = 0; k < 3; k++) begin
            m_sts[k] = '0;
            m_addr[k] = '0;
        end
    endtask

    // One cycle: check the read port and irq, advance the model, step the clock.
    task automatic tick(input string tag);
        logic [2:0]  n_pend;
        logic [2:0]  clrv;
        #1;
        check(tag == "" ? req_of(reg_addr) : tag, reg_rdata, exp_rd(reg_addr));
        check("R8", {31'd0, irq}, {31'd0, |(m_pend & m_mask)});
        clrv = (reg_wr && reg_addr == 6'h00) ? reg_wdata : 3'd0;
        for (int k = 0; k < 3; k++) begin
            n_pend[k] = e_vld[k] | (m_pend[k] & ~clrv[k]);
            if (e_vld[k] && (!m_pend[k] || clrv[k])) begin
                m_sts[k]  = exp_word(k, e_id[k], e_wr[k], sv_kind);
                m_addr[k] = e_addr[k];
            end
        end
        if (reg_wr && reg_addr == 6'h04) m_mask = reg_wdata;
        m_pend = n_pend;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic fault(input int k, input logic [5:0] id, input logic wr,
                         input logic [31:0] a);
        e_vld[k] = 1'b1; e_id[k] = id; e_wr[k] = wr; e_addr[k] = a;
    endtask

    task automatic rd(input logic [5:0] a, input string tag);
        reg_addr = a;
        tick(tag);
    endtask

    task automatic wr(input logic [5:0] a, input logic [2:0] d, input string tag);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
        tick(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [5:0] offs [10];
        void'($urandom(32'h00C0FFEE));
        offs = '{6'h00, 6'h04, 6'h10, 6'h14, 6'h18, 6'h1C, 6'h20, 6'h24, 6'h08, 6'h2C};
        for (int k = 0; k < 3; k++) begin
            e_id[k] = '0; e_wr[k] = 0; e_addr[k] = '0;
        end
        sv_kind = 0; reg_addr = '0;
        idle_inputs();
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register
        for (int i = 0; i < 10; i++) rd(offs[i], "R1");

        // R2: decode fault layout
        fault(0, 6'h2A, 1'b1, 32'hDEAD_0010);
        rd(6'h00, "R5");
        rd(6'h10, "R2");
        check("R2", m_sts[0], 32'h8000_002A);
        rd(6'h14, "R2");
        // R3: translation fault layout
        fault(1, 6'h3F, 1'b1, 32'h1234_5678);
        tick("R5");
        rd(6'h18, "R3");
        check("R3", m_sts[1], 32'h0000_007F);
        rd(6'h1C, "R3");
        // R4: security fault layout
        fault(2, 6'h05, 1'b0, 32'hCAFE_0004); sv_kind = 1'b1;
        tick("R5");
        sv_kind = 1'b0;
        rd(6'h20, "R4");
        check("R4", m_sts[2], 32'h4000_0005);
        rd(6'h24, "R4");
        rd(6'h00, "R5");
        check("R5", {29'd0, m_pend}, 32'd7);
        // R6: a second decode fault does not replace the first
        fault(0, 6'h01, 1'b0, 32'h0000_0BAD);
        tick("R6");
        rd(6'h10, "R6");
        rd(6'h14, "R6");
        // R8: mask selects the interrupt
        wr(6'h04, 3'b010, "R8");
        rd(6'h04, "R8");
        check("R8", {31'd0, irq}, 32'd1);
        // R7: clear only the decode bit
        wr(6'h00, 3'b001, "R7");
        rd(6'h00, "R7");
        // R9: clear and fault on the translation bit in one cycle
        fault(1, 6'h11, 1'b0, 32'h5555_AAAA);
        wr(6'h00, 3'b010, "R9");
        rd(6'h00, "R9");
        rd(6'h18, "R9");
        rd(6'h1C, "R9");
        // R10: capture registers ignore writes; unmapped reads are zero
        wr(6'h18, 3'b111, "R10");
        rd(6'h18, "R10");
        wr(6'h1C, 3'b101, "R10");
        rd(6'h1C, "R10");
        rd(6'h08, "R10");
        rd(6'h11, "R10");
        rd(6'h3C, "R10");
        wr(6'h00, 3'b111, "R7");
        rd(6'h00, "R7");
        wr(6'h04, 3'b000, "R8");

        // Random phase, checked against the model on every cycle
        for (int n = 0; n < 4000; n++) begin
            for (int k = 0; k < 3; k++) begin
                if ($urandom_range(3) == 0)
                    fault(k, 6'($urandom), 1'($urandom), $urandom);
            end
            sv_kind = 1'($urandom);
            case ($urandom_range(15))
                0, 1:    begin reg_addr = 6'h00; reg_wr = 1; reg_wdata = 3'($urandom); end
                2:       begin reg_addr = 6'h04; reg_wr = 1; reg_wdata = 3'($urandom); end
                3:       begin reg_addr = offs[$urandom_range(9)]; reg_wr = 1; reg_wdata = 3'($urandom); end
                4:       reg_addr = 6'($urandom);
                default: reg_addr = offs[$urandom_range(9)];
            endcase
            tick("");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule